// File: doc/BRIEF.md
# Flash Fetch Accelerator with Programmable Wait States

This block sits between a processor read port and a slow flash array that is read one wide line at a time. It keeps the most recent instruction line and the most recent data line in two holding latches. A read that finds its line in the right latch is answered one cycle after acceptance. A read that misses drives the line address to the flash for a programmable number of processor clocks, samples the line at the end, answers the processor and refills the latch.

Two small configuration registers are selected with `cfgSel`. The control register (`cfgSel`=0) holds the acceleration mode. The timing register (`cfgSel`=1) holds the flash access time in clocks. Software changes the timing safely by switching acceleration off, writing the new timing, and then re-enabling partial or full acceleration. The processor port carries one outstanding read at a time and a flag that marks the read as an instruction fetch or a data read.

Top module: `ffa_top`

## Requirements
- R1: After reset the mode field reads 00, the timing field reads 7, `reqReady` is 1 and `rspValid` is 0.
- R2: The mode is bits [1:0] of the control register: 00 off, 01 partial, 10 full. A write of 11 is ignored and the previous mode stays.
- R3: The timing is bits [2:0] of the timing register, a fetch of 1 to 7 clocks. A write takes effect only when the mode is 00 and the value is non-zero. Any other timing write is ignored.
- R4: With the mode off, every read goes to the flash. No latch is ever used.
- R5: With partial mode, only an instruction fetch whose line matches the instruction latch is served from a latch. Data reads always go to the flash.
- R6: With full mode, a read whose line matches the latch of its own kind (instruction or data) raises `rspValid` one cycle after acceptance, with no flash cycle.
- R7: On a miss, `flashRdEn` is high for exactly T cycles with `flashAddr` holding the line, and `rspValid` rises T+1 cycles after acceptance. T is the timing value. `rspData` is the word at offset `reqAddr[1:0]` of the line (word 0 in bits [31:0]). The line then fills the latch of that read's kind.
- R8: A control write that changes the mode invalidates both latches. A write of the current mode value keeps them.
- R9: Bits above the mode and timing fields are ignored on write and read back as zero.
- R10: A fetch in progress keeps the wait count it started with, even if the timing changes during the fetch.
- R11: `reqReady` is high only when no read is outstanding. A read is accepted on a cycle with `reqValid` and `reqReady` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the control register, 1 the timing register |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Contents of the selected register |
| reqValid | input | 1 | Read request |
| reqReady | output | 1 | Block can accept a read |
| reqAddr | input | 16 | Word address of the read |
| reqInstr | input | 1 | 1 for instruction fetch, 0 for data read |
| rspValid | output | 1 | One-cycle pulse with the read data |
| rspData | output | 32 | Read data word |
| flashRdEn | output | 1 | Flash access in progress |
| flashAddr | output | 14 | Line address presented to the flash |
| flashData | input | 128 | Line returned by the flash |

## Verification
The assertions assume that `flashData` is valid when the last cycle of the programmed access ends, and that configuration writes are single-cycle strobes. They also assume a read is only offered while `reqReady` is high. The bench keeps to this by driving a request for one cycle and waiting for its response before it offers the next. It presents the flash as a pure function of `flashAddr`, so the line is stable for the whole access. Random configuration writes are issued only between reads. The single case of a timing write during a fetch is a directed test.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
  localparam int CFG_W  = 8;
  localparam int MODE_W = 2;
  localparam int TIME_W = 3;
  localparam logic [TIME_W-1:0] TIME_RESET = 3'd7;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 2'b00,
    MODE_PART = 2'b01,
    MODE_FULL = 2'b10,
    MODE_RSVD = 2'b11
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hitRsp;      // answer from a latch
    logic startFetch;  // capture request, begin flash access
    logic fill;        // sample flash line, answer, refill latch
    logic invalidate;  // drop both latches
  } dpStrobe_t;
endpackage

// File: rtl/ffa_ctrl.sv
module ffa_ctrl
  import ffa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             reqValid,
  input  logic             reqInstr,
  output logic             reqReady,
  input  logic             hitInstr,
  input  logic             hitData,
  output logic             rspValid,
  output logic             flashRdEn,
  output dpStrobe_t        strb
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e              stateQ;
  accMode_e            modeQ;
  logic [TIME_W-1:0]   timingQ;
  logic [TIME_W-1:0]   cntQ;
  accMode_e            newMode;
  logic                modeTake;
  logic                timeTake;
  logic                accept;
  logic                hitSel;
  logic                lastCycle;

  always_comb begin
    newMode  = accMode_e'(cfgWrData[MODE_W-1:0]);
    modeTake = cfgWrEn && !cfgSel && (newMode != MODE_RSVD);
    timeTake = cfgWrEn && cfgSel && (modeQ == MODE_OFF) &&
               (cfgWrData[TIME_W-1:0] != '0);
    reqReady = (stateQ == ST_IDLE);
    accept   = reqValid && reqReady;
    lastCycle = (stateQ == ST_FETCH) && (cntQ == TIME_W'(1));
    flashRdEn = (stateQ == ST_FETCH);
    case (modeQ)
      MODE_FULL: hitSel = reqInstr ? hitInstr : hitData;
      MODE_PART: hitSel = reqInstr && hitInstr;
      default:   hitSel = 1'b0;
    endcase
    strb.hitRsp     = accept && hitSel;
    strb.startFetch = accept && !hitSel;
    strb.fill       = lastCycle;
    strb.invalidate = modeTake && (newMode != modeQ);
    cfgRdData = cfgSel ? {{(CFG_W-TIME_W){1'b0}}, timingQ}
                       : {{(CFG_W-MODE_W){1'b0}}, modeQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      modeQ    <= MODE_OFF;
      timingQ  <= TIME_RESET;
      cntQ     <= '0;
      rspValid <= 1'b0;
    end else begin
      if (modeTake) modeQ <= newMode;
      if (timeTake) timingQ <= cfgWrData[TIME_W-1:0];
      rspValid <= strb.hitRsp || lastCycle;
      if (strb.startFetch) begin
        stateQ <= ST_FETCH;
        cntQ   <= timingQ;
      end else if (lastCycle) begin
        stateQ <= ST_IDLE;
        cntQ   <= '0;
      end else if (stateQ == ST_FETCH) begin
        cntQ <= cntQ - TIME_W'(1);
      end
    end
  end

  assert_mode_rsvd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSel && cfgWrData[MODE_W-1:0] == 2'b11) |=> $stable(modeQ));

  assert_timing_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel && (modeQ != MODE_OFF || cfgWrData[TIME_W-1:0] == '0))
      |=> $stable(timingQ));

  assert_off_goes_flash_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && modeQ == MODE_OFF) |=> flashRdEn);

  assert_partial_data_flash_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && modeQ == MODE_PART && !reqInstr) |=> flashRdEn);

  assert_hit_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitRsp |=> (rspValid && !flashRdEn));

  assert_count_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> (cntQ != '0));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> !reqReady);
endmodule

// File: rtl/ffa_datapath.sv
module ffa_datapath
  import ffa_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqInstr,
  output logic              hitInstr,
  output logic              hitData,
  output logic [WORD_W-1:0] rspData,
  output logic [TAG_W-1:0]  flashAddr,
  input  logic [LINE_W-1:0] flashData
);
  localparam int KINDS = 2; // 0 instruction, 1 data

  logic [TAG_W-1:0]  reqTag;
  logic [OFF_W-1:0]  reqOff;
  logic              reqKind;
  logic [TAG_W-1:0]  pendTag;
  logic [OFF_W-1:0]  pendOff;
  logic              pendKind;
  logic [KINDS-1:0]  hitVec;
  logic [LINE_W-1:0] lineArr [KINDS];

  assign reqTag  = reqAddr[ADDR_W-1:OFF_W];
  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqKind = !reqInstr;
  assign flashAddr = pendTag;
  assign hitInstr  = hitVec[0];
  assign hitData   = hitVec[1];

  for (genvar g = 0; g < KINDS; g++) begin : g_latch
    logic              validQ;
    logic [TAG_W-1:0]  tagQ;
    logic [LINE_W-1:0] dataQ;
    logic              fillMe;
    assign fillMe    = strb.fill && (pendKind == 1'(g));
    assign hitVec[g] = validQ && (tagQ == reqTag);
    assign lineArr[g] = dataQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        tagQ   <= '0;
        dataQ  <= '0;
      end else if (fillMe) begin
        validQ <= 1'b1;
        tagQ   <= pendTag;
        dataQ  <= flashData;
      end else if (strb.invalidate) begin
        validQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTag  <= '0;
      pendOff  <= '0;
      pendKind <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.startFetch) begin
        pendTag  <= reqTag;
        pendOff  <= reqOff;
        pendKind <= reqKind;
      end
      if (strb.hitRsp)
        rspData <= lineArr[reqKind][reqOff*WORD_W +: WORD_W];
      else if (strb.fill)
        rspData <= flashData[pendOff*WORD_W +: WORD_W];
    end
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invalidate && !strb.fill) |=> (hitVec == '0));

  assert_fill_kind_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fill && !pendKind) |=> (hitInstr || (reqTag != $past(pendTag))));
endmodule

// File: rtl/ffa_top.sv
module ffa_top
  import ffa_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqInstr,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              flashRdEn,
  output logic [TAG_W-1:0]  flashAddr,
  input  logic [LINE_W-1:0] flashData
);
  dpStrobe_t strb;
  logic      hitInstr;
  logic      hitData;

  ffa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqInstr(reqInstr), .reqReady(reqReady),
    .hitInstr(hitInstr), .hitData(hitData),
    .rspValid(rspValid), .flashRdEn(flashRdEn), .strb(strb)
  );

  ffa_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqInstr(reqInstr),
    .hitInstr(hitInstr), .hitData(hitData),
    .rspData(rspData), .flashAddr(flashAddr), .flashData(flashData)
  );
endmodule

// File: tb/ffa_top_tb.sv
module ffa_top_tb;
  localparam int ADDR_W = 16, WORD_W = 32, LW = 4, OFF_W = 2;
  localparam int TAG_W = ADDR_W - OFF_W, LINE_W = WORD_W * LW;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [7:0] cfgWrData = '0, cfgRdData;
  logic reqValid = 1'b0, reqReady, reqInstr = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic rspValid, flashRdEn;
  logic [WORD_W-1:0] rspData;
  logic [TAG_W-1:0] flashAddr;
  logic [LINE_W-1:0] flashData;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;
  int modeM = 0, timeM = 7;
  bit validM [2];
  logic [TAG_W-1:0] tagM [2];

  always #5 clk = ~clk;

  ffa_top u_dut (.clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqInstr(reqInstr),
    .rspValid(rspValid), .rspData(rspData), .flashRdEn(flashRdEn),
    .flashAddr(flashAddr), .flashData(flashData));

  function automatic logic [31:0] flashWord(input logic [TAG_W-1:0] line, input int off);
    return (32'(line) * 32'h9E3779B1) ^ (32'(off) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  always_comb
    for (int i = 0; i < LW; i++) flashData[i*WORD_W +: WORD_W] = flashWord(flashAddr, i);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!sel) begin
      if (d[1:0] != 2'b11) begin
        if (int'(d[1:0]) != modeM) begin validM[0] = 0; validM[1] = 0; end
        modeM = int'(d[1:0]);
      end
    end else if (modeM == 0 && d[2:0] != 3'd0) timeM = int'(d[2:0]);
  endtask

  task automatic cfgCheck(input string req);
    @(negedge clk);
    cfgSel = 1'b0; #1;
    chk(cfgRdData == 8'(modeM), req, 32'(cfgRdData), 32'(modeM));
    cfgSel = 1'b1; #1;
    chk(cfgRdData == 8'(timeM), req, 32'(cfgRdData), 32'(timeM));
  endtask

  // one read; midT != 0 writes the timing register during the fetch
  task automatic doRead(input logic [ADDR_W-1:0] a, input bit instr, input logic [7:0] midT);
    int kind = instr ? 0 : 1;
    logic [TAG_W-1:0] line = a[ADDR_W-1:OFF_W];
    bit hit;
    int k = 0, fc = 0, tUse = timeM;
    string req;
    bit busySeen = 1'b0;
    if (modeM == 2) hit = validM[kind] && tagM[kind] == line;
    else if (modeM == 1) hit = instr && validM[0] && tagM[0] == line;
    else hit = 0;
    req = (modeM == 0) ? "R4" : (hit ? (modeM == 2 ? "R6" : "R5") : (modeM == 1 ? "R5" : "R7"));
    @(negedge clk);
    chk(reqReady == 1'b1, "R11", 32'(reqReady), 1);
    reqValid = 1'b1; reqAddr = a; reqInstr = instr;
    @(posedge clk);
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        reqValid = 1'b0;
        busySeen = !reqReady;
        if (midT != 0) begin cfgWrEn = 1'b1; cfgSel = 1'b1; cfgWrData = midT; end
      end
      if (k == 2) cfgWrEn = 1'b0;
      if (flashRdEn) fc++;
    end while (!rspValid && k < 20);
    cfgWrEn = 1'b0;
    if (midT != 0 && modeM == 0 && midT[2:0] != 0) timeM = int'(midT[2:0]);
    chk(k == (hit ? 1 : tUse + 1), req, 32'(k), 32'(hit ? 1 : tUse + 1));
    chk(fc == (hit ? 0 : tUse), hit ? req : "R7", 32'(fc), 32'(hit ? 0 : tUse));
    chk(rspData == flashWord(line, int'(a[OFF_W-1:0])), "R7 data", rspData,
        flashWord(line, int'(a[OFF_W-1:0])));
    if (!hit) chk(busySeen, "R11 busy", 32'(busySeen), 1);
    if (!hit) begin validM[kind] = 1; tagM[kind] = line; end
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    validM[0] = 0; validM[1] = 0; tagM[0] = '0; tagM[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(reqReady && !rspValid, "R1 handshake", {30'b0, reqReady, rspValid}, 32'h2);
    cfgCheck("R1");
    // R4 off mode: repeat of same line still fetches
    doRead(16'h0010, 1, 0);
    doRead(16'h0011, 1, 0);
    doRead(16'h0020, 0, 0);
    // R3 zero timing ignored; R9 upper bits ignored
    cfgWrite(1, 8'h00); cfgCheck("R3 zero");
    cfgWrite(1, 8'hFA); cfgCheck("R9 timing");
    // R2 reserved mode ignored, R9 upper bits
    cfgWrite(0, 8'h03); cfgCheck("R2 rsvd");
    cfgWrite(0, 8'hFE); cfgCheck("R9 mode");
    // R3 timing write while enabled ignored
    cfgWrite(1, 8'h05); cfgCheck("R3 locked");
    // R6 full mode
    doRead(16'h0040, 1, 0);
    doRead(16'h0043, 1, 0);
    doRead(16'h0080, 0, 0);
    doRead(16'h0082, 0, 0);
    doRead(16'h0041, 1, 0);
    // R8 mode change to partial flushes
    cfgWrite(0, 8'h01); cfgCheck("R2 partial");
    doRead(16'h0041, 1, 0);
    doRead(16'h0042, 1, 0);
    // R5 data always to flash in partial mode
    doRead(16'h0081, 0, 0);
    doRead(16'h0081, 0, 0);
    // R8 same mode write keeps latches
    cfgWrite(0, 8'h01);
    doRead(16'h0040, 1, 0);
    cfgWrite(0, 8'h02);
    doRead(16'h0040, 1, 0);
    // R10 timing change during a fetch
    cfgWrite(0, 8'h00);
    cfgWrite(1, 8'h05);
    doRead(16'h0100, 1, 8'h02);
    cfgCheck("R10 new timing");
    doRead(16'h0100, 1, 0);
    // random mix
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(99));
      if (r < 5) cfgWrite(0, 8'($urandom));
      else if (r < 10) cfgWrite(1, 8'($urandom));
      else if (r < 15) begin
        cfgWrite(0, 8'h00);
        cfgWrite(1, 8'($urandom_range(7)));
        cfgWrite(0, 8'($urandom_range(2, 1)));
        cfgCheck("R3 sequence");
      end else
        doRead(16'($urandom_range(31)), 1'($urandom), 0);
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule